// File: doc/BRIEF.md
# Nibble-Moded Basic GPIO Bank

This block controls sixteen general-purpose pins behind a small word-addressed register bus. The pins are split unevenly over four groups of 2, 4, 4 and 6 pins. Each group owns one data word and one configuration word. Every pin has a 4-bit mode nibble that selects input, output or one of a few alternate functions, and a data bit that software writes in output mode and reads as the synchronized pin level in input mode.

Alternate functions are legal only on particular pins. Pins 0 and 1 can carry two timer outputs. Pins 2 and 3 can carry a serial transmit line. Pins 4 and 5 can feed a serial receiver. A configuration write may request a mode that the pin does not support. In that case only the offending nibbles are refused, and a one-cycle error flag reports the refusal. The serial and timer engines themselves sit outside the block and connect through dedicated ports.

Top module: `gpio_nib_bank`

## Requirements
- R1: Group 0 holds pins 0-1, group 1 holds pins 2-5, group 2 holds pins 6-9 and group 3 holds pins 10-15. A pin's relative index k is its number minus its group's first pin (0, 2, 6 or 10). Bus word address g (0-3) is the data word of group g, and address 4+g is its configuration word.
- R2: In a data word, bit k belongs to the pin with relative index k. Bits beyond the group's pin count read as 0.
- R3: In a configuration word, bits 4k+3..4k hold the mode of the pin with relative index k and read back unchanged. Nibbles beyond the group's pin count read as 0, and writes to them are ignored without error.
- R4: Codes 0x0 (input) and 0x8 (output) are legal on every pin. 0x2 (serial receive) is legal only on pins 4-5. 0x9 is legal only on pins 0-3. 0xA is legal only on pins 0-1. Every other code is illegal. An illegal nibble leaves that pin's mode unchanged, while legal nibbles in the same write take effect.
- R5: `mode_err` is high for exactly the cycle after a configuration write that contained at least one illegal nibble, and low otherwise.
- R6: In mode 0x8 the pin is driven (`pin_oe`=1) with its data bit. Data-word writes change the stored bit only for pins in mode 0x8.
- R7: In modes 0x0 and 0x2 the pin is not driven. Its data bit reads the pin level through a two-flop synchronizer, so the level is visible to a read captured on the third clock edge after the pin changes. Writes to the data bit are ignored.
- R8: Mode 0x9 drives pins 0-1 from `tmr_a_i[pin]` and pins 2-3 from `ser_tx_i[pin-2]`. Mode 0xA drives pins 0-1 from `tmr_b_i[pin]`. In both modes `pin_oe`=1.
- R9: `ser_rx_o[j]` carries the synchronized level of pin 4+j while that pin is in mode 0x2, and 1 otherwise.
- R10: After reset every mode and data bit is 0, so all pins are inputs, `pin_oe`=0, `mode_err`=0 and `bus_rvalid`=0.
- R11: A read strobe captures the addressed word at that clock edge. `bus_rvalid` is high in the following cycle with that word on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data |
| bus_rvalid | output | 1 | Read data valid |
| mode_err | output | 1 | Illegal mode nibble refused |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin drive enables |
| tmr_a_i | input | 2 | Timer A outputs for pins 0-1 |
| tmr_b_i | input | 2 | Timer B outputs for pins 0-1 |
| ser_tx_i | input | 2 | Serial transmit lines for pins 2-3 |
| ser_rx_o | output | 2 | Serial receive lines from pins 4-5 |

## Verification
On every cycle, the in-module properties enforce three rules: a stored mode is always legal for its pin, a refused nibble leaves the mode as it was, and a data write to a non-output pin changes nothing. They also tie every drive enable to an output-class mode, every error pulse to a preceding write, and every read strobe to a valid beat. Other behaviour shows up only in the bench's scenarios. This covers where each pin's bit and nibble sit inside the uneven groups, the exact two-edge latency of the synchronizer, and the selection of the right peripheral line per pin. It also covers partial acceptance of a write that mixes legal and illegal nibbles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int NUM_PINS = 16;
   localparam int NUM_GRP  = 4;
   localparam int MODE_W   = 4;

   localparam int GRP_BASE [NUM_GRP] = '{0, 2, 6, 10};
   localparam int GRP_SIZE [NUM_GRP] = '{2, 4, 4, 6};
   localparam int MAX_GRP_SIZE = 6;

   localparam logic [MODE_W-1:0] MODE_IN    = 4'h0;
   localparam logic [MODE_W-1:0] MODE_RX    = 4'h2;
   localparam logic [MODE_W-1:0] MODE_OUT   = 4'h8;
   localparam logic [MODE_W-1:0] MODE_ALT_A = 4'h9;
   localparam logic [MODE_W-1:0] MODE_ALT_B = 4'hA;

   // group index owning a pin
   function automatic int grp_of(input int pin);
      if (pin < 2)       return 0;
      else if (pin < 6)  return 1;
      else if (pin < 10) return 2;
      else               return 3;
   endfunction

   // legality of a mode code on a given pin
   function automatic logic mode_ok(input logic [MODE_W-1:0] m, input int pin);
      case (m)
         MODE_IN, MODE_OUT: return 1'b1;
         MODE_RX:           return (pin == 4) || (pin == 5);
         MODE_ALT_A:        return pin < 4;
         MODE_ALT_B:        return pin < 2;
         default:           return 1'b0;
      endcase
   endfunction

   function automatic logic mode_drives(input logic [MODE_W-1:0] m);
      return (m == MODE_OUT) || (m == MODE_ALT_A) || (m == MODE_ALT_B);
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_chk
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-2:0], d_i};
   end

   assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
   import gpio_bank_pkg::*;
#(
   parameter int PIN         = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [MODE_W-1:0] cfg_nib,
   input  logic              dat_we,
   input  logic              dat_bit,
   input  logic              pad_i,
   input  logic              alt_a_i,
   input  logic              alt_b_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              rd_bit_o,
   output logic              pad_o,
   output logic              pad_oe,
   output logic              rx_o,
   output logic              nib_bad_o
);
   if (PIN < 0 || PIN >= NUM_PINS) begin : g_chk
      $error("gpio_pin_slice: PIN out of range");
   end

   logic [MODE_W-1:0] mode_q;
   logic              data_q;
   logic              lvl_sync;
   logic              nib_legal;
   logic              is_input;

   gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_i),
      .q_o   (lvl_sync)
   );

   assign nib_legal = mode_ok(cfg_nib, PIN);
   assign nib_bad_o = cfg_we && !nib_legal;
   assign is_input  = (mode_q == MODE_IN) || (mode_q == MODE_RX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_IN;
      end else if (cfg_we && nib_legal) begin
         mode_q <= cfg_nib;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= 1'b0;
      end else if (dat_we && (mode_q == MODE_OUT)) begin
         data_q <= dat_bit;
      end
   end

   always_comb begin
      pad_o = 1'b0;
      case (mode_q)
         MODE_OUT:   pad_o = data_q;
         MODE_ALT_A: pad_o = alt_a_i;
         MODE_ALT_B: pad_o = alt_b_i;
         default:    pad_o = 1'b0;
      endcase
   end

   assign pad_oe   = mode_drives(mode_q);
   assign rd_bit_o = is_input ? lvl_sync : data_q;
   assign rx_o     = (mode_q == MODE_RX) ? lvl_sync : 1'b1;
   assign mode_o   = mode_q;

   // R4: stored mode never leaves the legal set of this pin
   a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ok(mode_q, PIN));

   // R4: a refused nibble keeps the previous mode
   a_r4_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !mode_ok(cfg_nib, PIN)) |=> (mode_q == $past(mode_q)));

   // R7: data writes to a non-output pin have no effect
   a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && (mode_q != MODE_OUT)) |=> $stable(data_q));

   // R6: drive enable only in output-class modes
   a_r6_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe |-> mode_q[3]);
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [NUM_PINS-1:0][MODE_W-1:0] pin_mode,
   input  logic [NUM_PINS-1:0]             pin_bit,
   input  logic                            sel_cfg,
   input  logic [1:0]                      sel_grp,
   output logic [DATA_W-1:0]               word_o
);
   logic [NUM_GRP-1:0][DATA_W-1:0] dat_w;
   logic [NUM_GRP-1:0][DATA_W-1:0] cfg_w;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      for (genvar k = 0; k < GRP_SIZE[g]; k++) begin : g_pin
         assign dat_w[g][k]          = pin_bit[GRP_BASE[g] + k];
         assign cfg_w[g][4*k +: 4]   = pin_mode[GRP_BASE[g] + k];
      end
      for (genvar b = GRP_SIZE[g]; b < DATA_W; b++) begin : g_dpad
         assign dat_w[g][b] = 1'b0;
      end
      for (genvar b = MODE_W * GRP_SIZE[g]; b < DATA_W; b++) begin : g_cpad
         assign cfg_w[g][b] = 1'b0;
      end
   end

   assign word_o = sel_cfg ? cfg_w[sel_grp] : dat_w[sel_grp];
endmodule

// File: rtl/gpio_nib_bank.sv
module gpio_nib_bank
   import gpio_bank_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr_en,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_rd_en,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_rvalid,
   output logic                mode_err,
   input  logic [15:0]         pin_in,
   output logic [15:0]         pin_out,
   output logic [15:0]         pin_oe,
   input  logic [1:0]          tmr_a_i,
   input  logic [1:0]          tmr_b_i,
   input  logic [1:0]          ser_tx_i,
   output logic [1:0]          ser_rx_o
);
   localparam int CFG_BITS = MODE_W * MAX_GRP_SIZE;

   if (DATA_W < CFG_BITS) begin : g_chk_w
      $error("gpio_nib_bank: DATA_W too narrow for the widest group");
   end
   if (ADDR_W < 3) begin : g_chk_a
      $error("gpio_nib_bank: ADDR_W must be at least 3");
   end
   if (SYNC_STAGES < 2) begin : g_chk_s
      $error("gpio_nib_bank: SYNC_STAGES must be at least 2");
   end

   logic                            addr_ok;
   logic                            sel_cfg;
   logic [1:0]                      sel_grp;
   logic                            wr_cfg;
   logic                            wr_dat;
   logic [NUM_PINS-1:0][MODE_W-1:0] pin_mode;
   logic [NUM_PINS-1:0]             pin_bit;
   logic [NUM_PINS-1:0]             nib_bad;
   logic [NUM_PINS-1:0]             rx_lvl;
   logic [DATA_W-1:0]               mux_word;
   logic [DATA_W-1:0]               rdata_q;
   logic                            rvalid_q;
   logic                            err_q;

   if (ADDR_W > 3) begin : g_hi_addr
      assign addr_ok = ~|bus_addr[ADDR_W-1:3];
   end else begin : g_no_hi
      assign addr_ok = 1'b1;
   end

   assign sel_cfg = bus_addr[2];
   assign sel_grp = bus_addr[1:0];
   assign wr_cfg  = bus_wr_en && addr_ok && sel_cfg;
   assign wr_dat  = bus_wr_en && addr_ok && !sel_cfg;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int G = grp_of(p);
      localparam int K = p - GRP_BASE[G];
      logic alt_a;
      logic alt_b;

      if (p < 2) begin : g_tmr
         assign alt_a = tmr_a_i[p];
         assign alt_b = tmr_b_i[p];
      end else if (p < 4) begin : g_tx
         assign alt_a = ser_tx_i[p-2];
         assign alt_b = 1'b0;
      end else begin : g_none
         assign alt_a = 1'b0;
         assign alt_b = 1'b0;
      end

      gpio_pin_slice #(
         .PIN         (p),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (wr_cfg && (sel_grp == 2'(G))),
         .cfg_nib   (bus_wdata[MODE_W*K +: MODE_W]),
         .dat_we    (wr_dat && (sel_grp == 2'(G))),
         .dat_bit   (bus_wdata[K]),
         .pad_i     (pin_in[p]),
         .alt_a_i   (alt_a),
         .alt_b_i   (alt_b),
         .mode_o    (pin_mode[p]),
         .rd_bit_o  (pin_bit[p]),
         .pad_o     (pin_out[p]),
         .pad_oe    (pin_oe[p]),
         .rx_o      (rx_lvl[p]),
         .nib_bad_o (nib_bad[p])
      );
   end

   assign ser_rx_o = rx_lvl[5:4];

   gpio_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .pin_mode (pin_mode),
      .pin_bit  (pin_bit),
      .sel_cfg  (sel_cfg),
      .sel_grp  (sel_grp),
      .word_o   (mux_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= bus_rd_en;
         if (bus_rd_en) rdata_q <= addr_ok ? mux_word : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= |nib_bad;
   end

   assign bus_rdata  = rdata_q;
   assign bus_rvalid = rvalid_q;
   assign mode_err   = err_q;

   // R5: an error pulse always follows a bus write
   a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> $past(bus_wr_en));

   // R11: every read strobe yields a valid beat next cycle
   a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> bus_rvalid);

   // R11: valid only after a strobe
   a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_rd_en));
endmodule

// File: tb/gpio_nib_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_nib_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        mode_err;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic [1:0]  tmr_a_i = '0;
   logic [1:0]  tmr_b_i = '0;
   logic [1:0]  ser_tx_i = '0;
   logic [1:0]  ser_rx_o;

   int n_checks = 0;
   int n_err = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_item_t;
   exp_item_t exp_q[$];

   always #2.5 clk = ~clk;

   gpio_nib_bank dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
      .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .mode_err(mode_err), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .tmr_a_i(tmr_a_i), .tmr_b_i(tmr_b_i), .ser_tx_i(ser_tx_i), .ser_rx_o(ser_rx_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: called right after a posedge (+1ns)
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(posedge clk); #1;
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      exp_item_t it;
      it.exp = exp; it.tag = tag;
      exp_q.push_back(it);
      bus_addr = a; bus_rd_en = 1'b1;
      @(posedge clk); #1;
      bus_rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // monitor: compares read beats against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            chk("R11 unexpected rvalid", 32'h1, 32'h0);
         end else begin
            exp_item_t it;
            it = exp_q.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         n_checks++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // R10 reset state
      chk("R10 pin_oe", {16'h0, pin_oe}, 32'h0);
      chk("R10 mode_err", {31'h0, mode_err}, 32'h0);
      chk("R10 rvalid", {31'h0, bus_rvalid}, 32'h0);
      chk("R9 rx idle high", {30'h0, ser_rx_o}, 32'h3);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      rd(3'd4, 32'h0, "R10 cfg0 reset");
      rd(3'd7, 32'h0, "R10 cfg3 reset");

      // R3/R1: group 3 all output, upper nibbles ignored without error
      wr(3'd7, 32'hFF88_8888);
      chk("R3 no err on unused nibbles", {31'h0, mode_err}, 32'h0);
      rd(3'd7, 32'h0088_8888, "R3 cfg3 readback");
      chk("R6 oe group3", {16'h0, pin_oe}, 32'h0000_FC00);

      // R2/R6: data bits at relative index, stored in output mode
      wr(3'd3, 32'hFFFF_FFC5);
      rd(3'd3, 32'h0000_0005, "R2 data3 readback");
      chk("R6 pin_out group3", {26'h0, pin_out[15:10]}, 32'h05);

      // R7: input-mode writes ignored, level read through sync
      pin_in[5:2] = 4'b1010;
      idle(3);
      wr(3'd1, 32'h0000_0005);
      rd(3'd1, 32'h0000_000A, "R7 data1 input level, write ignored");

      // R7: exact two-flop latency on pin 6 (group 2, bit 0)
      pin_in[6] = 1'b1;
      rd(3'd2, 32'h0, "R7 sync edge1");
      rd(3'd2, 32'h0, "R7 sync edge2");
      rd(3'd2, 32'h1, "R7 sync edge3");

      // R4/R1: legal alternate modes on group 1
      wr(3'd5, 32'h0000_2299);
      chk("R4 legal write no err", {31'h0, mode_err}, 32'h0);
      rd(3'd5, 32'h0000_2299, "R4 cfg1 legal");
      // R4/R5: pins 2,3 refuse 0x2, pins 4,5 accept
      wr(3'd5, 32'h0000_2222);
      chk("R5 err pulse", {31'h0, mode_err}, 32'h1);
      idle(1);
      chk("R5 err single cycle", {31'h0, mode_err}, 32'h0);
      rd(3'd5, 32'h0000_2299, "R4 partial accept");
      // R4: illegal code 0x1 on pin 4 and 0xA on pin 2
      wr(3'd5, 32'h0000_219A);
      chk("R5 err pulse 2", {31'h0, mode_err}, 32'h1);
      rd(3'd5, 32'h0000_2299, "R4 illegal codes refused");

      // R9: pins 4,5 in receive mode -> ser_rx_o = {pin5,pin4} = 10
      chk("R9 rx levels", {30'h0, ser_rx_o}, 32'h2);
      // R7/R6: rx pins read level, alt pins read stored 0
      rd(3'd1, 32'h0000_0008, "R7 data1 mixed modes");

      // R8: pins 2,3 carry serial transmit
      ser_tx_i = 2'b01; #1;
      chk("R8 tx pins", {30'h0, pin_out[3:2]}, 32'h1);
      chk("R8 oe tx pins", {30'h0, pin_oe[3:2]}, 32'h3);
      ser_tx_i = 2'b10; #1;
      chk("R8 tx pins swap", {30'h0, pin_out[3:2]}, 32'h2);

      // R8: pin0 timer A, pin1 timer B
      wr(3'd4, 32'h0000_00A9);
      tmr_a_i = 2'b11; tmr_b_i = 2'b00; #1;
      chk("R8 timer pins", {30'h0, pin_out[1:0]}, 32'h1);
      tmr_b_i = 2'b10; tmr_a_i = 2'b00; #1;
      chk("R8 timer B pin1", {30'h0, pin_out[1:0]}, 32'h2);
      chk("R8 oe timer pins", {30'h0, pin_oe[1:0]}, 32'h3);
      rd(3'd4, 32'h0000_00A9, "R1 cfg0 readback");

      // R7: group 3 back to input, level reads and oe drops
      pin_in[15:10] = 6'b110011;
      wr(3'd7, 32'h0);
      chk("R7 oe dropped", {16'h0, pin_oe}, 32'h0000_000F);
      idle(2);
      rd(3'd3, 32'h0000_0033, "R7 data3 input level");

      idle(4);
      chk("R11 scoreboard drained", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule